// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

The router gathers a set of level-sensitive peripheral interrupt request lines and folds them onto the nine general-purpose interrupt lines of a processor core. Each source owns a small routing field. The value in that field names one core line, and the block drives each core line with the OR of every source that is enabled and routed to it. Prioritising the core lines is left to the core event logic downstream.

Software reaches the block through a flat word-wide register port. A write takes effect at the clock edge where it is presented. A read is combinational from the address. Two or more routing words hold the per-source fields, one word holds the per-source enable bits, and one read-only word shows the raw source levels. Reset loads a fixed, non-uniform default routing and leaves every source disabled.

Top module: `irq_router`

## Requirements
- R1: After reset the routing fields hold the default map: sources 0 to 6 select line 0, sources 7 and 8 select line 1, sources 9 to 12 select line 2, and source 13 selects line 3. With 14 sources, word 0 reads 0x10000000 and word 1 reads 0x00322221.
- R2: After reset the enable word (address 8) reads zero, and every core line stays low whatever the source levels.
- R3: The field of source s is 4 bits wide, in word s/8 at bits 4*(s%8)+3..4*(s%8), and reads back as written. A field value n from 0 to 8 drives core_irq[n], which is general interrupt level 7+n.
- R4: A core line is high when at least one enabled source routed to it is high, and low when none is.
- R5: A source whose enable bit (address 8, bit s) is clear has no effect on any core line.
- R6: A field value from 9 to 15 routes its source to no core line.
- R7: core_irq is registered. A source change seen at clock edge k shows on core_irq after edge k and not before.
- R8: A routing write presented at edge k leaves core_irq on the old routing after edge k and shows the new routing after edge k+1.
- R9: Address 9 reads the raw source levels whatever the enable bits. Writes to address 9 change no state. Bits above the source count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | NUM_SRC | Peripheral interrupt request levels |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| core_irq | output | NUM_CORE | Core interrupt lines; bit n is general level 7+n |

## Verification
Corruption in a routing field has no effect while its source is quiet. It shows one edge after that source rises, as a pulse on the wrong core line or as no pulse at all. The bench therefore raises every source alone and checks that exactly one line answers. A stale enable bit shows on the same one-edge schedule, and a wrong register is caught by readback at the port in the cycle it is addressed. The bench checks both sides of the R7 and R8 latency edges, so logic that runs one cycle early or one cycle late is caught.

// File: rtl/irq_router_pkg.sv
// Package: shared constants and reset routing for the interrupt router.
// Assumes 4-bit routing fields and a 32-bit register port.
package irq_router_pkg;

    localparam int FIELD_W      = 4;
    localparam int REG_W        = 32;
    localparam int FIELDS_PER_W = REG_W / FIELD_W;
    localparam int ADDR_W       = 4;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 4'd8;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd9;

    localparam logic [FIELD_W-1:0] ROUTE_NONE = 4'hF;

    // Reset-time core line for a source; sources past the default table go nowhere.
    function automatic logic [FIELD_W-1:0] default_route(input int src);
        if (src <= 6)       return 4'd0;
        else if (src <= 8)  return 4'd1;
        else if (src <= 12) return 4'd2;
        else if (src == 13) return 4'd3;
        else                return ROUTE_NONE;
    endfunction

endpackage

// File: rtl/irq_router_regs.sv
// Register file of the router: per-source routing fields, enable word,
// and a combinational read mux that also exposes the raw source levels.
// Assumes NUM_SRC <= DATA_W and that the routing words sit below ADDR_ENABLE.
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int DATA_W  = REG_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NUM_SRC-1:0]         src_raw,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_SRC*FIELD_W-1:0] route,
    output logic [NUM_SRC-1:0]         enable
);

    localparam int FPW    = DATA_W / FIELD_W;
    localparam int N_ASGN = (NUM_SRC + FPW - 1) / FPW;
    localparam int PAD_W  = N_ASGN * DATA_W;

    logic [PAD_W-1:0] route_pad;

    // One routing field per source, loaded from the default map at reset.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
        localparam logic [ADDR_W-1:0] WORD = ADDR_W'(s / FPW);
        localparam int                LSB  = (s % FPW) * FIELD_W;

        // Purpose: hold the routing field of source s.
        always_ff @(posedge clk) begin
            if (!rst_n)
                route[s*FIELD_W +: FIELD_W] <= default_route(s);
            else if (wr_en && addr == WORD)
                route[s*FIELD_W +: FIELD_W] <= wdata[LSB +: FIELD_W];
        end

        // R3: a write to the owning word lands in this field on the next cycle.
        a_r3_field_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == WORD) |=> route[s*FIELD_W +: FIELD_W] == $past(wdata[LSB +: FIELD_W]));
    end

    // Purpose: hold the per-source enable bits, cleared at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= '0;
        else if (wr_en && addr == ADDR_ENABLE)
            enable <= wdata[NUM_SRC-1:0];
    end

    // Zero-pad the fields so every routing word is full width.
    if (PAD_W > NUM_SRC*FIELD_W) begin : g_pad
        assign route_pad = {{(PAD_W-NUM_SRC*FIELD_W){1'b0}}, route};
    end else begin : g_nopad
        assign route_pad = route;
    end

    // Purpose: select read data from the addressed word.
    always_comb begin
        rdata = '0;
        if (int'(addr) < N_ASGN)
            rdata = route_pad[int'(addr)*DATA_W +: DATA_W];
        else if (addr == ADDR_ENABLE)
            rdata = DATA_W'(enable);
        else if (addr == ADDR_STATUS)
            rdata = DATA_W'(src_raw);
    end

    // R2/R5: the enable word follows the last write to its address.
    a_r5_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_ENABLE) |=> enable == $past(wdata[NUM_SRC-1:0]));

    // R9: a write to the status address leaves the enable bits unchanged.
    a_r9_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STATUS) |=> $stable(enable));

endmodule

// File: rtl/irq_router_xbar.sv
// Routing matrix: decodes each source field against every core line,
// ORs the enabled matches per line and registers the result.
// Assumes route values >= NUM_CORE match no line.
module irq_router_xbar
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC  = 14,
    parameter int NUM_CORE = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src,
    input  logic [NUM_SRC-1:0]         enable,
    input  logic [NUM_SRC*FIELD_W-1:0] route,
    output logic [NUM_CORE-1:0]        core_irq
);

    logic [NUM_SRC-1:0]  active;
    logic [NUM_SRC-1:0]  in_range;
    logic [NUM_CORE-1:0] hit;

    assign active = src & enable;

    // Flag sources whose field names a real core line.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_range
        assign in_range[s] = int'(route[s*FIELD_W +: FIELD_W]) < NUM_CORE;
    end

    // One OR tree per core line over the sources that select it.
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_line
        logic [NUM_SRC-1:0] sel;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign sel[s] = route[s*FIELD_W +: FIELD_W] == FIELD_W'(c);
        end
        assign hit[c] = |(active & sel);
    end

    // Purpose: register the core lines for one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) core_irq <= '0;
        else        core_irq <= hit;
    end

    // R5: with no enabled source high, every line is low next cycle.
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> core_irq == '0);

    // R6: sources routed out of range never raise a line.
    a_r6_nowhere: assert property (@(posedge clk) disable iff (!rst_n)
        ((active & in_range) == '0) |=> core_irq == '0);

    // R4: an enabled, high, in-range source raises some line next cycle.
    a_r4_some_line: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(active & in_range) != 0) |=> core_irq != '0);

endmodule

// File: rtl/irq_router.sv
// Top of the interrupt router: register file plus routing matrix.
// core_irq[n] feeds general interrupt level 7+n of the core event logic.
// Assumes level-sensitive, already-synchronous source lines.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC  = 14,
    parameter int NUM_CORE = 9,
    parameter int DATA_W   = REG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_irq,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_CORE-1:0] core_irq
);

    logic [NUM_SRC*FIELD_W-1:0] route;
    logic [NUM_SRC-1:0]         enable;

    irq_router_regs #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .src_raw (src_irq),
        .rdata   (reg_rdata),
        .route   (route),
        .enable  (enable)
    );

    irq_router_xbar #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CORE (NUM_CORE)
    ) u_xbar (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_irq),
        .enable   (enable),
        .route    (route),
        .core_irq (core_irq)
    );

    // R2: core lines stay low on the first cycle out of reset.
    a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> core_irq == '0);

endmodule

// File: tb/irq_router_tb.sv
// Directed bench for irq_router: one task per scenario, each self-checking.
module irq_router_tb;

    localparam int NS = 14;
    localparam int NC = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_irq = '0;
    logic          reg_wr_en = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NC-1:0] core_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int rt [NS];
    logic [NS-1:0] en_m = '0;
    int cyc = 0;

    always #2 clk = ~clk;

    irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_irq(core_irq)
    );

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary_and_end();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] model_out();
        logic [NC-1:0] e = '0;
        for (int s = 0; s < NS; s++)
            if (src_irq[s] && en_m[s] && rt[s] < NC) e[rt[s]] = 1'b1;
        return e;
    endfunction

    function automatic logic [31:0] model_word(input int w);
        logic [31:0] v = '0;
        for (int f = 0; f < 8; f++)
            if (w*8 + f < NS) v[f*4 +: 4] = 4'(rt[w*8 + f]);
        return v;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0; src_irq = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        rd(4'd0, d); check("R1 word0 default", d, 32'h1000_0000);
        rd(4'd1, d); check("R1 word1 default", d, 32'h0032_2221);
        rd(4'd8, d); check("R2 enable reset", d, 32'h0);
        step();
        check("R2 lines low with sources high", 32'(core_irq), 32'h0);
    endtask

    task automatic t_default_route();
        wr(4'd8, 32'h3FFF); en_m = '1;
        for (int s = 0; s < NS; s++) begin
            src_irq = NS'(1) << s;
            step();
            check($sformatf("R1 default line of src %0d", s), 32'(core_irq), 32'(model_out()));
        end
        src_irq = '0; step();
    endtask

    task automatic t_latency();
        src_irq = NS'(1) << 7;
        #1 check("R7 not before edge", 32'(core_irq), 32'h0);
        step();
        check("R7 after one edge", 32'(core_irq), 32'h002);
        src_irq = '0;
        #1 check("R7 fall not before edge", 32'(core_irq), 32'h002);
        step();
        check("R7 fall after edge", 32'(core_irq), 32'h0);
    endtask

    task automatic t_route_all();
        logic [NC-1:0] old_e;
        logic [31:0] d;
        src_irq = NS'(1) << 3;
        step();
        for (int n = 0; n < NC; n++) begin
            old_e = model_out();
            rt[3] = n;
            wr(4'd0, model_word(0));
            check($sformatf("R8 old route held, idx %0d", n), 32'(core_irq), 32'(old_e));
            step();
            check($sformatf("R3 index %0d drives bit %0d", n, n), 32'(core_irq), 32'(1) << n);
            rd(4'd0, d); check("R3 field readback", d, model_word(0));
        end
        src_irq = '0; step();
    endtask

    task automatic t_or_merge();
        rt[2] = 4; rt[5] = 4; rt[10] = 4;
        wr(4'd0, model_word(0)); wr(4'd1, model_word(1));
        src_irq = '0; src_irq[2] = 1; src_irq[5] = 1; src_irq[10] = 1;
        step(); check("R4 three sources one line", 32'(core_irq), 32'h010);
        src_irq[2] = 0; step(); check("R4 two left", 32'(core_irq), 32'h010);
        src_irq[10] = 0; step(); check("R4 one left", 32'(core_irq), 32'h010);
        src_irq[5] = 0; step(); check("R4 none left", 32'(core_irq), 32'h0);
    endtask

    task automatic t_mask_status();
        logic [31:0] d;
        wr(4'd8, 32'h0001); en_m = 14'h0001;
        src_irq = 14'h3FFE;
        step(); check("R5 disabled sources ignored", 32'(core_irq), 32'h0);
        rd(4'd9, d); check("R9 status raw levels", d, 32'h0000_3FFE);
        src_irq = 14'h3FFF;
        step(); check("R5 enabled source passes", 32'(core_irq), 32'(model_out()));
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd8, d); check("R9 status write leaves enable", d, 32'h0000_0001);
        rd(4'd0, d); check("R9 status write leaves routing", d, model_word(0));
        rd(4'd9, d); check("R9 status after write", d, 32'h0000_3FFF);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        src_irq = 14'h0001;
        rt[0] = 9; wr(4'd0, model_word(0)); step();
        check("R6 value 9 routes nowhere", 32'(core_irq), 32'h0);
        rd(4'd0, d); check("R6 field 9 readback", d, model_word(0));
        rt[0] = 15; wr(4'd0, model_word(0)); step();
        check("R6 value 15 routes nowhere", 32'(core_irq), 32'h0);
        rt[0] = 8; wr(4'd0, model_word(0)); step();
        check("R3 value 8 drives top line", 32'(core_irq), 32'h100);
        src_irq = '0; step();
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            rt[s] = (s <= 6) ? 0 : (s <= 8) ? 1 : (s <= 12) ? 2 : 3;
        t_reset();
        t_default_route();
        t_latency();
        t_route_all();
        t_or_merge();
        t_mask_status();
        t_out_of_range();
        summary_and_end();
    end

endmodule